// File: doc/BRIEF.md
# Transceiver Transmit Reset Sequencer

This block brings up the transmit half of a serial transceiver. A one-cycle start request holds the transmit PLL reset and the PCS reset high together for a fixed number of cycles. The block then waits for a fresh low-to-high transition on the lock flag of whichever PLL clocks the transmit path. A lock flag that is already high does not count. After a fixed settling delay it drives one or more reset pulses into the output clock dividers, each with a guaranteed minimum high time and a guaranteed minimum low time between pulses. It then reports completion.

If the selected lock flag drops while the divider phase is running, the sequence is abandoned: the divider reset is released and the block waits for a new lock edge. On its own, and at any time, the block watches the 2-bit line-rate select. Any change in that value produces a fixed-length transmit buffer reset, and also withdraws a completion already reported.

Top module: `txrst_top`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the cycle after it, divRst, pllRst, pcsRst, bufRst and done are all 0.
- R2: When start is sampled high at a clock edge, pllRst is 1 for exactly PLL_RST_W (8) cycles starting after that edge, then returns to 0. A new start at any time restarts this.
- R3: The sequence is armed only by a 0-to-1 change of the selected lock flag seen after pllRst has dropped. The selected flag is txPllLock when useRxPll is 0 and rxPllLock when useRxPll is 1. A flag that stays high, the unselected flag, and edges seen while pllRst is high have no effect.
- R4: The first divRst pulse rises LOCK_WAIT (1024) cycles after the edge at which the lock transition was sampled.
- R5: Each divRst pulse stays high for PULSE_W (256) cycles.
- R6: Consecutive divRst pulses are separated by GAP_W (256) low cycles. The number of pulses equals pulseReq as sampled with the lock transition, and pulseReq = 0 selects DEF_PULSES (1).
- R7: pcsRst equals pllRst on every cycle.
- R8: If the selected lock flag is sampled low during the delay or pulse phase, divRst is 0 from the next cycle and the block waits for a fresh lock transition.
- R9: A change of rateSel between consecutive sampled cycles drives bufRst high for BUF_RST_W (16) cycles. A further change while bufRst is high restarts the full count.
- R10: done rises GAP_W cycles after the last pulse falls, that is LOCK_WAIT + N·(PULSE_W+GAP_W) cycles after the lock edge, and stays high until a start or a rateSel change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new reset sequence |
| txPllLock | input | 1 | Transmit PLL lock flag |
| rxPllLock | input | 1 | Receive PLL lock flag |
| useRxPll | input | 1 | 1: transmit path clocked by receive PLL |
| rateSel | input | 2 | Line-rate select |
| pulseReq | input | PCNT_W (3) | Requested divider pulse count, 0 = default |
| divRst | output | 1 | Output clock divider reset |
| pllRst | output | 1 | Transmit PLL reset |
| pcsRst | output | 1 | Transmit PCS reset |
| bufRst | output | 1 | Transmit buffer reset |
| done | output | 1 | Sequence complete |

## Verification
The sequence is first started with the lock flag already high, which shows whether a level is wrongly taken for an edge. It is then run with a clean transmit-PLL edge and the default count, with three requested pulses, and with the receive PLL selected while the other flag toggles. Together these separate the edge, source-selection and pulse-count logic. An edge placed inside the PLL reset window, lock losses during the delay and during a pulse, and a start issued mid-sequence test the abort and restart paths. Single and back-to-back rate changes, applied both after completion and during a sequence, show whether the buffer pulse restarts its count and whether it withdraws completion only once completion has been reached.

// File: rtl/txrst_pkg.sv
package txrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLLRST,
    ST_WAITLOCK,
    ST_DELAY,
    ST_PULSE,
    ST_GAP,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    TM_PLL,
    TM_LOCK,
    TM_HIGH,
    TM_GAP
  } tmrSel_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic    loadTmr;
    tmrSel_t tmrSel;
    logic    pllSet;
    logic    pllClr;
    logic    divSet;
    logic    divClr;
    logic    latchCount;
    logic    decCount;
  } seqStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/txrst_dpath.sv
module txrst_dpath
  import txrst_pkg::*;
#(
  parameter int LOCK_WAIT     = 1024,
  parameter int PULSE_W       = 256,
  parameter int GAP_W         = 256,
  parameter int PLL_RST_W     = 8,
  parameter int BUF_RST_W     = 16,
  parameter int PCNT_W        = 3,
  parameter int DEF_PULSES    = 1,
  parameter bit AUTO_RATE_RST = 1'b1,
  parameter int RATE_W        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txPllLock,
  input  logic              rxPllLock,
  input  logic              useRxPll,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [PCNT_W-1:0] pulseReq,
  input  seqStrobe_t        strb,
  output logic              lockRise,
  output logic              lockNow,
  output logic              tmrDone,
  output logic              lastPulse,
  output logic              rateChg,
  output logic              divRst,
  output logic              pllRst,
  output logic              pcsRst,
  output logic              bufRst
);

  localparam int TMR_MAX = maxOf4(LOCK_WAIT, PULSE_W, GAP_W, PLL_RST_W);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BUF_W   = $clog2(BUF_RST_W + 1);
  localparam int GAPC_W  = $clog2(GAP_W + 1);

  // Lock source selection and edge detection
  logic selLock;
  logic lockPrev;

  assign selLock = useRxPll ? rxPllLock : txPllLock;

  always_ff @(posedge clk) begin
    if (!rstN) lockPrev <= 1'b1;   // a flag high out of reset is not an edge
    else       lockPrev <= selLock;
  end

  assign lockRise = selLock & ~lockPrev;
  assign lockNow  = selLock;

  // Shared down-counter for all phase durations
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] loadVal;

  always_comb begin
    unique case (strb.tmrSel)
      TM_PLL:  loadVal = TMR_W'(PLL_RST_W - 1);
      TM_LOCK: loadVal = TMR_W'(LOCK_WAIT - 1);
      TM_HIGH: loadVal = TMR_W'(PULSE_W - 1);
      default: loadVal = TMR_W'(GAP_W - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               tmr <= '0;
    else if (strb.loadTmr)   tmr <= loadVal;
    else if (tmr != '0)      tmr <= tmr - 1'b1;
  end

  assign tmrDone = (tmr == '0);

  // Pulse counter
  logic [PCNT_W-1:0] pulsesLeft;

  always_ff @(posedge clk) begin
    if (!rstN)
      pulsesLeft <= '0;
    else if (strb.latchCount)
      pulsesLeft <= (pulseReq == '0) ? PCNT_W'(DEF_PULSES) : pulseReq;
    else if (strb.decCount && pulsesLeft != '0)
      pulsesLeft <= pulsesLeft - 1'b1;
  end

  assign lastPulse = (pulsesLeft <= PCNT_W'(1));

  // Reset output registers
  always_ff @(posedge clk) begin
    if (!rstN)             divRst <= 1'b0;
    else if (strb.divClr)  divRst <= 1'b0;
    else if (strb.divSet)  divRst <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pllRst <= 1'b0;
    else if (strb.pllSet)  pllRst <= 1'b1;
    else if (strb.pllClr)  pllRst <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pcsRst <= 1'b0;
    else if (strb.pllSet)  pcsRst <= 1'b1;
    else if (strb.pllClr)  pcsRst <= 1'b0;
  end

  // Rate change detection and buffer reset
  generate
    if (AUTO_RATE_RST) begin : g_rate
      logic [RATE_W-1:0] ratePrev;
      logic [BUF_W-1:0]  bufTmr;
      logic              bufQ;

      always_ff @(posedge clk) begin
        if (!rstN) ratePrev <= rateSel;
        else       ratePrev <= rateSel;
      end

      assign rateChg = (rateSel != ratePrev);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          bufTmr <= '0;
          bufQ   <= 1'b0;
        end else if (rateChg) begin
          bufTmr <= BUF_W'(BUF_RST_W - 1);
          bufQ   <= 1'b1;
        end else if (bufTmr != '0) begin
          bufTmr <= bufTmr - 1'b1;
        end else begin
          bufQ   <= 1'b0;
        end
      end

      assign bufRst = bufQ;

      // R9: a sampled rate change is followed by an active buffer reset
      p_buf_on_change_r9: assert property (@(posedge clk) disable iff (!rstN)
        rateChg |=> bufRst);
    end else begin : g_norate
      assign rateChg = 1'b0;
      assign bufRst  = 1'b0;
    end
  endgenerate

  // Low-time counter used to guard the gap between pulses
  logic [GAPC_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                           lowCnt <= '0;
    else if (divRst)                     lowCnt <= '0;
    else if (lowCnt != GAPC_W'(GAP_W))   lowCnt <= lowCnt + 1'b1;
  end

  // R6: a divider pulse never starts before a full gap of low time
  p_gap_before_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divRst) |-> (lowCnt == GAPC_W'(GAP_W)));

  // R8: losing the selected lock releases the divider reset next cycle
  p_lock_loss_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lockNow |=> !divRst);

endmodule

// File: rtl/txrst_ctrl.sv
module txrst_ctrl
  import txrst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lockRise,
  input  logic       lockNow,
  input  logic       tmrDone,
  input  logic       lastPulse,
  input  logic       rateChg,
  output seqStrobe_t strb,
  output logic       done
);

  seqState_t state, nxt;

  always_comb begin
    strb = '0;
    nxt  = state;
    if (start) begin
      nxt          = ST_PLLRST;
      strb.pllSet  = 1'b1;
      strb.divClr  = 1'b1;
      strb.loadTmr = 1'b1;
      strb.tmrSel  = TM_PLL;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_PLLRST: begin
          if (tmrDone) begin
            nxt         = ST_WAITLOCK;
            strb.pllClr = 1'b1;
          end
        end
        ST_WAITLOCK: begin
          if (lockRise) begin
            nxt             = ST_DELAY;
            strb.loadTmr    = 1'b1;
            strb.tmrSel     = TM_LOCK;
            strb.latchCount = 1'b1;
          end
        end
        ST_DELAY, ST_PULSE, ST_GAP: begin
          if (!lockNow) begin
            nxt         = ST_WAITLOCK;
            strb.divClr = 1'b1;
          end else if (tmrDone) begin
            if (state == ST_PULSE) begin
              nxt          = ST_GAP;
              strb.divClr  = 1'b1;
              strb.loadTmr = 1'b1;
              strb.tmrSel  = TM_GAP;
            end else if (state == ST_GAP && lastPulse) begin
              nxt = ST_DONE;
            end else begin
              nxt           = ST_PULSE;
              strb.divSet   = 1'b1;
              strb.loadTmr  = 1'b1;
              strb.tmrSel   = TM_HIGH;
              strb.decCount = (state == ST_GAP);
            end
          end
        end
        ST_DONE: begin
          if (rateChg) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign done = (state == ST_DONE);

  // R10: a start request always withdraws completion
  p_start_clears_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

  // R10: completion is only reached from the trailing gap
  p_done_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(state) == ST_GAP));

endmodule

// File: rtl/txrst_top.sv
module txrst_top
  import txrst_pkg::*;
#(
  parameter int LOCK_WAIT     = 1024,
  parameter int PULSE_W       = 256,
  parameter int GAP_W         = 256,
  parameter int PLL_RST_W     = 8,
  parameter int BUF_RST_W     = 16,
  parameter int PCNT_W        = 3,
  parameter int DEF_PULSES    = 1,
  parameter bit AUTO_RATE_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              txPllLock,
  input  logic              rxPllLock,
  input  logic              useRxPll,
  input  logic [1:0]        rateSel,
  input  logic [PCNT_W-1:0] pulseReq,
  output logic              divRst,
  output logic              pllRst,
  output logic              pcsRst,
  output logic              bufRst,
  output logic              done
);

  localparam int HIGHC_W = $clog2(PULSE_W + 1);

  seqStrobe_t strb;
  logic lockRise, lockNow, tmrDone, lastPulse, rateChg;

  txrst_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lockRise (lockRise),
    .lockNow  (lockNow),
    .tmrDone  (tmrDone),
    .lastPulse(lastPulse),
    .rateChg  (rateChg),
    .strb     (strb),
    .done     (done)
  );

  txrst_dpath #(
    .LOCK_WAIT    (LOCK_WAIT),
    .PULSE_W      (PULSE_W),
    .GAP_W        (GAP_W),
    .PLL_RST_W    (PLL_RST_W),
    .BUF_RST_W    (BUF_RST_W),
    .PCNT_W       (PCNT_W),
    .DEF_PULSES   (DEF_PULSES),
    .AUTO_RATE_RST(AUTO_RATE_RST),
    .RATE_W       (2)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .txPllLock(txPllLock),
    .rxPllLock(rxPllLock),
    .useRxPll (useRxPll),
    .rateSel  (rateSel),
    .pulseReq (pulseReq),
    .strb     (strb),
    .lockRise (lockRise),
    .lockNow  (lockNow),
    .tmrDone  (tmrDone),
    .lastPulse(lastPulse),
    .rateChg  (rateChg),
    .divRst   (divRst),
    .pllRst   (pllRst),
    .pcsRst   (pcsRst),
    .bufRst   (bufRst)
  );

  // High-time counter guarding the divider pulse width
  logic [HIGHC_W-1:0] highCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                             highCnt <= '0;
    else if (!divRst)                      highCnt <= '0;
    else if (highCnt != HIGHC_W'(PULSE_W)) highCnt <= highCnt + 1'b1;
  end

  // R5: a pulse that ends normally has lasted the full width
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(divRst) && $past(lockNow) && !$past(start)) |-> (highCnt == HIGHC_W'(PULSE_W)));

  // R7: PCS reset moves together with the PLL reset
  p_pcs_follow_pll_r7: assert property (@(posedge clk) disable iff (!rstN)
    pcsRst == pllRst);

  // R10: completion never coincides with an active divider or PLL reset
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!divRst && !pllRst));

endmodule

// File: tb/test_txrst_top.sv
module test_txrst_top;

  localparam int LW     = 1024;
  localparam int PW     = 256;
  localparam int GW     = 256;
  localparam int PLLW   = 8;
  localparam int BUFW   = 16;
  localparam int PCNT_W = 3;
  localparam int DEFP   = 1;

  localparam int M_IDLE = 0, M_PLL = 1, M_WAIT = 2, M_SEQ = 3, M_DONE = 4;

  logic clk = 1'b0;
  logic rstN, start, txPllLock, rxPllLock, useRxPll;
  logic [1:0] rateSel;
  logic [PCNT_W-1:0] pulseReq;
  logic divRst, pllRst, pcsRst, bufRst, done;

  always #10 clk = ~clk;   // 50 MHz

  txrst_top #(
    .LOCK_WAIT(LW), .PULSE_W(PW), .GAP_W(GW), .PLL_RST_W(PLLW),
    .BUF_RST_W(BUFW), .PCNT_W(PCNT_W), .DEF_PULSES(DEFP), .AUTO_RATE_RST(1'b1)
  ) i_txrst_top (
    .clk(clk), .rstN(rstN), .start(start), .txPllLock(txPllLock),
    .rxPllLock(rxPllLock), .useRxPll(useRxPll), .rateSel(rateSel),
    .pulseReq(pulseReq), .divRst(divRst), .pllRst(pllRst), .pcsRst(pcsRst),
    .bufRst(bufRst), .done(done)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit finished = 0;

  // Behavioural reference model, timed by absolute cycle numbers
  int mode = M_IDLE;
  int pllStart = 0, lockAt = 0, nPulses = 1, bufLeft = 0;
  bit prevLock = 1;
  logic [1:0] prevRate = 2'd0;
  bit modelValid = 0;
  bit eDiv = 0, ePll = 0, eBuf = 0, eDone = 0;

  always @(posedge clk) begin
    bit sel, rise, rchg;
    int off;
    cyc++;
    if (!rstN) begin
      mode = M_IDLE; prevLock = 1; prevRate = rateSel; bufLeft = 0;
    end else begin
      sel = useRxPll ? rxPllLock : txPllLock;
      rise = sel && !prevLock;
      prevLock = sel;
      rchg = (rateSel !== prevRate);
      prevRate = rateSel;
      if (rchg) bufLeft = BUFW;
      else if (bufLeft > 0) bufLeft--;
      if (start) begin
        mode = M_PLL; pllStart = cyc;
      end else begin
        case (mode)
          M_PLL:  if (cyc - pllStart >= PLLW) mode = M_WAIT;
          M_WAIT: if (rise) begin
                    mode = M_SEQ; lockAt = cyc;
                    nPulses = (pulseReq == 0) ? DEFP : int'(pulseReq);
                  end
          M_SEQ:  if (!sel) mode = M_WAIT;
                  else if (cyc - lockAt >= LW + nPulses * (PW + GW)) mode = M_DONE;
          M_DONE: if (rchg) mode = M_IDLE;
          default: ;
        endcase
      end
    end
    off  = cyc - lockAt;
    eDiv = (mode == M_SEQ) && (off >= LW) && (((off - LW) % (PW + GW)) < PW);
    ePll = (mode == M_PLL);
    eBuf = (bufLeft > 0);
    eDone = (mode == M_DONE);
    modelValid = 1;
  end

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, name, cyc, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (modelValid && !finished) begin
      vectors++;
      chk("R3/R4/R5/R6/R8", "divRst", divRst, eDiv);
      chk("R1/R2", "pllRst", pllRst, ePll);
      chk("R7", "pcsRst", pcsRst, ePll);
      chk("R9", "bufRst", bufRst, eBuf);
      chk("R10", "done", done, eDone);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual still running, expected finished");
      finish();
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; txPllLock = 1'b1; rxPllLock = 1'b0;
    useRxPll = 1'b0; rateSel = 2'd0; pulseReq = '0;
    tick(4);
    // R1: outputs low during and after reset
    chk("R1", "reset state", divRst | pllRst | pcsRst | bufRst | done, 1'b0);
    rstN = 1'b1;
    tick(2);

    // R2, R3: start with lock already high; no arming
    pulseStart();
    tick(1500);

    // R3, R4, R5, R10: clean edge on transmit PLL lock, default pulse count
    txPllLock = 1'b0; tick(5);
    txPllLock = 1'b1;
    tick(LW + PW + GW + 30);

    // R9, R10: rate change withdraws done, then back-to-back changes
    rateSel = 2'd1; tick(30);
    rateSel = 2'd2; tick(5);
    rateSel = 2'd3; tick(40);

    // R3, R6: three pulses, with an edge inside the PLL reset window ignored
    pulseReq = 3'd3;
    txPllLock = 1'b0;
    pulseStart();
    tick(2);
    txPllLock = 1'b1;   // rises while pllRst is high
    tick(20);
    txPllLock = 1'b0; tick(2);
    txPllLock = 1'b1;
    tick(LW + 3 * (PW + GW) + 30);

    // R3, R8: receive PLL selected; abort during a pulse, then re-arm
    useRxPll = 1'b1; pulseReq = 3'd2; rxPllLock = 1'b0;
    pulseStart();
    tick(12);
    txPllLock = 1'b0; tick(3); txPllLock = 1'b1;  // unselected flag
    tick(3);
    rxPllLock = 1'b1;
    tick(LW + 100);
    rxPllLock = 1'b0; tick(5);
    rxPllLock = 1'b1;
    tick(LW + 2 * (PW + GW) + 30);

    // R8: abort during the settling delay, rate change mid-sequence
    pulseReq = 3'd0;
    pulseStart();
    tick(12);
    rxPllLock = 1'b0; tick(3); rxPllLock = 1'b1;
    tick(300);
    rateSel = 2'd0;       // R9 during a sequence: done not affected later
    tick(100);
    rxPllLock = 1'b0; tick(4); rxPllLock = 1'b1;
    tick(LW + 50);

    // R2: start issued mid-pulse restarts everything
    pulseStart();
    tick(20);
    rxPllLock = 1'b0; tick(2); rxPllLock = 1'b1;
    tick(LW + PW + GW + 30);

    finish();
  end

endmodule